// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host side of a link to a 12-bit serial analog-to-digital converter. A one-cycle start request makes it pull chip select low, and the fall of chip select is the moment the converter samples its input. The block then produces 16 serial clock periods from a divided system clock. SCLK is held high when chip select falls, so the converter gets the longest possible track window. On each SCLK falling edge the block captures one bit of the serial data. The converter launches each bit on the previous falling edge, and it places the first bit on the line as soon as chip select falls.

Each frame carries four leading zeros and then a 12-bit result, most significant bit first. After the 16th falling edge the block waits one more half period, then raises chip select and returns SCLK to high. In that same cycle it presents the result with a one-cycle done pulse and a flag that shows whether any leading bit was captured as one. A quiet interval follows before the next frame may begin. A start request that arrives during the quiet interval is held and served as soon as the interval ends. A start request that arrives during a frame is dropped.

Top module: `adc_frame_reader`

## Requirements
- R1: Each frame has exactly 16 SCLK falling edges while chip select is low, and chip select never rises before the 16th of them.
- R2: SCLK is high whenever chip select is high, including the cycle in which chip select falls.
- R3: Inside a frame every SCLK high or low phase lasts exactly HALF_CLKS system clocks, and the first falling edge comes HALF_CLKS clocks after chip select falls.
- R4: The serial input is captured at each SCLK falling edge. The result holds the last 12 captured bits: the bit captured 5th is result bit 11 and the bit captured 16th is result bit 0.
- R5: The error flag is 1 exactly when at least one of the first four captured bits is 1. The flag is valid in the done cycle.
- R6: The done output pulses for one cycle, in the cycle in which chip select returns high. That happens HALF_CLKS clocks after the 16th falling edge.
- R7: Between two frames chip select stays high for at least QUIET_CLKS+1 system clocks.
- R8: A start request that arrives during the quiet interval is held. Its frame begins with chip select falling exactly QUIET_CLKS+1 clocks after the previous rise.
- R9: A start request that arrives while chip select is low has no effect, and no extra frame follows.
- R10: Busy is low at idle and after reset. It is high from the cycle after a start is accepted, through the frame, and for QUIET_CLKS cycles after done, then it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion frame |
| busy_o | output | 1 | Frame or quiet interval in progress |
| done_o | output | 1 | One-cycle result valid pulse |
| data_o | output | DATA_BITS | Converted value, MSB first on the wire |
| frame_err_o | output | 1 | A leading bit was captured as one |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| sdata_i | input | 1 | Serial data from the converter |

## Verification
The converter model replays words with alternating bits, all zeros, all ones, and a single bit set at either end. Together these show that the bit order is correct, that no capture is off by one, and that the first bit, which is present before any clock edge, is not lost. Frames with a one in the first or in the last leading position exercise the error flag at both ends of the leading field. Start requests placed in the middle of a frame and inside the quiet interval separate a dropped request from a held one, and the exact chip-select gap shows when a held request is served.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_FRAME = 2'd1,
      RD_QUIET = 2'd2
   } rd_state_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/adc_rd_halfclk.sv
module adc_rd_halfclk #(
   parameter int unsigned HALF_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int unsigned CW = adc_rd_pkg::cnt_width(HALF_CLKS);

   generate
      if (HALF_CLKS == 1) begin : g_every
         assign tick_o = run_i;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);
         logic [CW-1:0] cnt_q;

         assign tick_o = run_i && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i || tick_o) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
   parameter int unsigned LEAD_BITS = 4,
   parameter int unsigned DATA_BITS = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_i,
   input  logic                 bit_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 lead_err_o
);
   localparam int unsigned FRAME_BITS = LEAD_BITS + DATA_BITS;

   logic [FRAME_BITS-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (cap_i) begin
         sh_q <= {sh_q[FRAME_BITS-2:0], bit_i};
      end
   end

   assign data_o = sh_q[DATA_BITS-1:0];

   generate
      if (LEAD_BITS > 0) begin : g_lead
         assign lead_err_o = |sh_q[FRAME_BITS-1:DATA_BITS];
      end else begin : g_nolead
         assign lead_err_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/adc_rd_quiet.sv
module adc_rd_quiet #(
   parameter int unsigned QUIET_CLKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic req_i,
   input  logic take_i,
   output logic expire_o,
   output logic pend_o
);
   localparam int unsigned CW = adc_rd_pkg::cnt_width(QUIET_CLKS);
   localparam logic [CW-1:0] LAST = CW'(QUIET_CLKS - 1);

   logic [CW-1:0] cnt_q;
   logic          pend_q;

   assign expire_o = run_i && (cnt_q == LAST);
   assign pend_o   = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || expire_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (take_i) begin
         pend_q <= 1'b0;
      end else if (req_i) begin
         pend_q <= 1'b1;
      end
   end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
   parameter int unsigned HALF_CLKS  = 4,
   parameter int unsigned QUIET_CLKS = 20,
   parameter int unsigned LEAD_BITS  = 4,
   parameter int unsigned DATA_BITS  = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 frame_err_o,
   output logic                 cs_n_o,
   output logic                 sclk_o,
   input  logic                 sdata_i
);
   import adc_rd_pkg::*;

   localparam int unsigned FRAME_BITS = LEAD_BITS + DATA_BITS;
   localparam int unsigned PHASES     = 2 * FRAME_BITS;
   localparam int unsigned PH_W       = $clog2(PHASES);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

   generate
      if (HALF_CLKS < 1) begin : g_bad_half
         $error("HALF_CLKS must be at least 1");
      end
      if (QUIET_CLKS < 1) begin : g_bad_quiet
         $error("QUIET_CLKS must be at least 1");
      end
      if (DATA_BITS < 1) begin : g_bad_data
         $error("DATA_BITS must be at least 1");
      end
   endgenerate

   rd_state_e           state_q;
   logic [PH_W-1:0]     ph_q;
   logic                cs_n_q;
   logic                sclk_q;
   logic                done_q;
   logic [DATA_BITS-1:0] data_q;
   logic                err_q;

   logic                tick;
   logic                cap;
   logic                frame_end;
   logic                launch;
   logic                q_expire;
   logic                q_pend;
   logic [DATA_BITS-1:0] sh_data;
   logic                sh_err;

   assign launch    = (state_q == RD_IDLE) && (start_i || q_pend);
   assign cap       = tick && !ph_q[0];
   assign frame_end = tick && (ph_q == PH_LAST);

   adc_rd_halfclk #(.HALF_CLKS(HALF_CLKS)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state_q == RD_FRAME),
      .tick_o (tick)
   );

   adc_rd_shifter #(.LEAD_BITS(LEAD_BITS), .DATA_BITS(DATA_BITS)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_i      (cap),
      .bit_i      (sdata_i),
      .data_o     (sh_data),
      .lead_err_o (sh_err)
   );

   adc_rd_quiet #(.QUIET_CLKS(QUIET_CLKS)) u_quiet (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (state_q == RD_QUIET),
      .req_i    (start_i && (state_q == RD_QUIET)),
      .take_i   (launch),
      .expire_o (q_expire),
      .pend_o   (q_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
         ph_q    <= '0;
         cs_n_q  <= 1'b1;
         sclk_q  <= 1'b1;
         done_q  <= 1'b0;
         data_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            RD_IDLE: begin
               if (launch) begin
                  state_q <= RD_FRAME;
                  cs_n_q  <= 1'b0;
                  sclk_q  <= 1'b1;
                  ph_q    <= '0;
               end
            end
            RD_FRAME: begin
               if (frame_end) begin
                  state_q <= RD_QUIET;
                  cs_n_q  <= 1'b1;
                  sclk_q  <= 1'b1;
                  done_q  <= 1'b1;
                  data_q  <= sh_data;
                  err_q   <= sh_err;
               end else if (tick) begin
                  ph_q   <= ph_q + 1'b1;
                  sclk_q <= ~sclk_q;
               end
            end
            RD_QUIET: begin
               if (q_expire) begin
                  state_q <= RD_IDLE;
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != RD_IDLE);
   assign done_o      = done_q;
   assign data_o      = data_q;
   assign frame_err_o = err_q;
   assign cs_n_o      = cs_n_q;
   assign sclk_o      = sclk_q;
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
   parameter int unsigned HALF_CLKS  = 4,
   parameter int unsigned QUIET_CLKS = 20,
   parameter int unsigned LEAD_BITS  = 4,
   parameter int unsigned DATA_BITS  = 12
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic done_o,
   input logic cs_n_o,
   input logic sclk_o
);
   localparam int unsigned FRAME_BITS = LEAD_BITS + DATA_BITS;
   localparam int unsigned CW = 16;
   localparam logic [CW-1:0] CNT_MAX = '1;

   logic          sclk_d;
   logic          cs_d;
   logic [CW-1:0] fall_cnt;
   logic [CW-1:0] run_cnt;
   logic [CW-1:0] hi_cnt;
   logic          seen_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d     <= 1'b1;
         cs_d       <= 1'b1;
         fall_cnt   <= '0;
         run_cnt    <= CW'(1);
         hi_cnt     <= '0;
         seen_frame <= 1'b0;
      end else begin
         sclk_d <= sclk_o;
         cs_d   <= cs_n_o;
         if (cs_n_o) fall_cnt <= '0;
         else if (sclk_d && !sclk_o) fall_cnt <= fall_cnt + 1'b1;
         if ((sclk_o != sclk_d) || (cs_n_o != cs_d)) run_cnt <= CW'(1);
         else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
         if (!cs_n_o) hi_cnt <= '0;
         else if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
         if (done_o) seen_frame <= 1'b1;
      end
   end

   a_r1_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (fall_cnt == CW'(FRAME_BITS)));

   a_r2_select_with_high_clock: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> sclk_o);

   a_r2_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o);

   a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_d && ((sclk_o != sclk_d) || (cs_n_o != cs_d))) |-> (run_cnt == CW'(HALF_CLKS)));

   a_r6_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $rose(cs_n_o));

   a_r6_release_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> done_o);

   a_r7_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n_o) && seen_frame) |-> (hi_cnt >= CW'(QUIET_CLKS + 1)));

   a_r10_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_o |-> busy_o);
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
   .HALF_CLKS  (HALF_CLKS),
   .QUIET_CLKS (QUIET_CLKS),
   .LEAD_BITS  (LEAD_BITS),
   .DATA_BITS  (DATA_BITS)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy_o (busy_o),
   .done_o (done_o),
   .cs_n_o (cs_n_o),
   .sclk_o (sclk_o)
);

// File: tb/tb_adc_frame_reader.sv
`timescale 1ns/1ps
module tb_adc_frame_reader;
   localparam int HALF  = 2;
   localparam int QUIET = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done, ferr, cs_n, sclk;
   logic [11:0] data;
   logic        sdata = 1'b1;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   adc_frame_reader #(.HALF_CLKS(HALF), .QUIET_CLKS(QUIET)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
      .data_o(data), .frame_err_o(ferr), .cs_n_o(cs_n), .sclk_o(sclk), .sdata_i(sdata));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // converter model: bit launched 1 ns after chip-select fall or SCLK fall
   logic [15:0] dev_word = '0;
   int          dev_idx = 0;
   always @(negedge cs_n) begin
      #1 dev_idx = 0;
      sdata = dev_word[15];
   end
   always @(negedge sclk) begin
      if (!cs_n) begin
         #1 dev_idx++;
         sdata = (dev_idx < 16) ? dev_word[15 - dev_idx] : 1'b0;
      end
   end
   always @(posedge cs_n) sdata = 1'b1;

   // scoreboard
   logic [12:0] exp_q[$];
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R4", "unexpected done", 1, 0);
         end else begin
            logic [12:0] e;
            e = exp_q.pop_front();
            check(data == e[11:0], "R4", "result", data, e[11:0]);
            check(ferr == e[12], "R5", "error flag", ferr, e[12]);
         end
      end
   end

   // pin timing tracker
   logic prev_cs = 1'b1, prev_sclk = 1'b1;
   int   run = 0, falls = 0, gap = 0, last_gap = 0, frames = 0;
   bit   seen = 0, half_bad = 0, busy_bad = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_cs == 1'b1 && cs_n == 1'b0) begin
            check(sclk == 1'b1, "R2", "sclk at select", sclk, 1);
            if (seen) check(gap >= QUIET + 1, "R7", "quiet gap", gap, QUIET + 1);
            last_gap = gap;
            frames++;
            falls = 0; half_bad = 0; busy_bad = 0;
         end
         if ((prev_cs == 1'b0) && ((cs_n != prev_cs) || (sclk != prev_sclk)) && run != HALF)
            half_bad = 1;
         if (!cs_n && prev_sclk && !sclk) falls++;
         if (!cs_n && !busy) busy_bad = 1;
         if (prev_cs == 1'b0 && cs_n == 1'b1) begin
            check(falls == 16, "R1", "falling edges", falls, 16);
            check(!half_bad, "R3 R6", "half periods", half_bad, 0);
            check(!busy_bad, "R10", "busy in frame", busy_bad, 0);
            check(done == 1'b1, "R6", "done at release", done, 1);
            seen = 1;
            gap = 0;
         end
         if (cs_n) begin
            check(sclk == 1'b1, "R2", "idle sclk", sclk, 1);
            gap++;
         end
         if ((cs_n != prev_cs) || (sclk != prev_sclk)) run = 1;
         else run++;
         prev_cs = cs_n;
         prev_sclk = sclk;
      end
   end

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(done == 1'b1, req, "done seen", done, 1);
   endtask

   task automatic load(input logic [3:0] lead, input logic [11:0] val);
      dev_word = {lead, val};
      exp_q.push_back({|lead, val});
   endtask

   task automatic run_frame(input logic [3:0] lead, input logic [11:0] val);
      load(lead, val);
      pulse_start();
      wait_done("R4");
      repeat (QUIET - 1) @(negedge clk);
      check(busy == 1'b1, "R10", "busy in quiet", busy, 1);
      @(negedge clk);
      check(busy == 1'b0, "R10", "busy after quiet", busy, 0);
   endtask

   initial begin
      #(200000 * 4);
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check(cs_n == 1'b1, "R2", "reset cs", cs_n, 1);
      check(sclk == 1'b1, "R2", "reset sclk", sclk, 1);
      check(busy == 1'b0, "R10", "reset busy", busy, 0);
      check(done == 1'b0, "R6", "reset done", done, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_frame(4'h0, 12'hA5C);
      run_frame(4'h0, 12'h000);
      run_frame(4'h0, 12'hFFF);
      run_frame(4'h0, 12'h555);
      run_frame(4'h0, 12'h001);
      run_frame(4'h0, 12'h800);
      run_frame(4'h8, 12'h123);   // R5 first leading bit set
      run_frame(4'h1, 12'hFED);   // R5 last leading bit set

      // R9: start during a frame is dropped
      begin
         int f0;
         f0 = frames;
         load(4'h0, 12'h3C3);
         pulse_start();
         repeat (20) @(negedge clk);
         pulse_start();
         wait_done("R9");
         repeat (QUIET + 40) @(negedge clk);
         check(frames == f0 + 1, "R9", "frame count", frames, f0 + 1);
         check(busy == 1'b0, "R9", "idle afterwards", busy, 0);
      end

      // R8: start during quiet is held and served at expiry
      begin
         int f0;
         load(4'h0, 12'h6A9);
         pulse_start();
         wait_done("R8");
         f0 = frames;
         repeat (2) @(negedge clk);
         load(4'h0, 12'h96A);
         pulse_start();
         wait_done("R8");
         check(frames == f0 + 1, "R8", "held frame ran", frames, f0 + 1);
         check(last_gap == QUIET + 1, "R8", "held frame gap", last_gap, QUIET + 1);
         repeat (QUIET + 3) @(negedge clk);
      end

      check(exp_q.size() == 0, "R4", "results left", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule